// File: doc/BRIEF.md
# Packed Q15 Rounding Multiply Unit

This block is a SIMD datapath for fixed-point signal work. Two operand vectors of up to 256 bits are cut into signed 16-bit lanes. Each active lane multiplies its two values, scales the product down by 2^15 with round-half-up, and returns the 16-bit result. There is no saturation: the one overflowing case wraps.

A 2-bit mode input sets how many lanes are active: 4, 8 or 16. In the 4-lane mode and in one of the two 8-lane modes, the lanes above the active span are copied from a third input that carries the old destination value. In the other 8-lane mode those lanes are cleared. A separate length bit is used only to detect the one illegal combination, which is a wide length on the clearing 8-lane mode. That case raises a flag and leaves the result untouched.

Results are registered once. A legal request shows up on the outputs one cycle after it is presented.

Top module: `q15_rmul_unit`

## Requirements
- R1: In every active lane, the result is bits 16:1 of ((a*b) >>> 14) + 1, where a and b are the signed 16-bit lane operands and the product is a signed 32-bit value.
- R2: The lane has no saturation. -32768 * -32768 gives 16'h8000. 16'h7FFF * 16'h7FFF gives 16'h7FFE. 1*1, -1*1 and 0*x all give 0.
- R3: Lane i reads bits 16i+15:16i of both operands and writes bits 16i+15:16i of the result.
- R4: Mode 2'b00 computes lanes 0..3. Result bits 255:64 equal the old-destination input.
- R5: Mode 2'b01 computes lanes 0..7. Result bits 255:128 equal the old-destination input.
- R6: Mode 2'b10 computes lanes 0..7. Result bits 255:128 are zero.
- R7: Mode 2'b11 computes all 16 lanes.
- R8: resValid is high in exactly the cycle after a legal inValid. resData changes only at those points and holds otherwise.
- R9: inValid with mode 2'b10 and lenBit=1 is illegal. One cycle later illegalOp is high for one cycle, resValid is low and resData keeps its previous value. lenBit has no effect in any other mode.
- R10: While rstN is low, resData is zero and resValid and illegalOp are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request strobe |
| modeSel | input | 2 | 00 = 4 lanes keep, 01 = 8 lanes keep, 10 = 8 lanes clear, 11 = 16 lanes |
| lenBit | input | 1 | Length bit; only used to detect the illegal case |
| srcA | input | 256 | First operand vector |
| srcB | input | 256 | Second operand vector |
| oldDest | input | 256 | Old destination value, merged above the active lanes |
| resData | output | 256 | Registered result |
| resValid | output | 1 | Result updated this cycle |
| illegalOp | output | 1 | Illegal mode and length combination was requested |

## Verification
The merge assertions assume that oldDest stays meaningful only in the cycle a request is presented, and compare the upper result bits against that sampled value one cycle later. The hold assertion assumes that nothing apart from a legal strobe may change the result register. The stimulus drives every input on the falling edge and keeps it stable through the capturing edge. It mixes legal, illegal and idle cycles, including lenBit=1 on the modes that ignore it, so that each assertion sees both sides of its antecedent.

// File: rtl/q15_rmul_pkg.sv
`timescale 1ns/1ps
package q15_rmul_pkg;
  typedef enum logic [1:0] {
    MODE_W64       = 2'b00,
    MODE_W128_KEEP = 2'b01,
    MODE_W128_ZERO = 2'b10,
    MODE_W256      = 2'b11
  } mode_e;

  typedef enum logic [1:0] {
    SPAN_QUARTER = 2'b00,
    SPAN_HALF    = 2'b01,
    SPAN_FULL    = 2'b10
  } span_e;

  typedef struct packed {
    logic  load;
    logic  flagIllegal;
    span_e span;
    logic  zeroRest;
  } ctrl_t;
endpackage

// File: rtl/q15_rmul_lane.sv
`timescale 1ns/1ps
module q15_rmul_lane #(
  parameter int LANE_W = 16,
  parameter int SHIFT  = 14
) (
  input  logic [LANE_W-1:0] opA,
  input  logic [LANE_W-1:0] opB,
  output logic [LANE_W-1:0] laneOut
);
  localparam int PROD_W = 2 * LANE_W;

  logic signed [PROD_W-1:0] prod;
  logic        [LANE_W:0]   rounded;
  logic                     unusedBits;

  assign prod       = $signed(opA) * $signed(opB);
  assign rounded    = prod[SHIFT+LANE_W:SHIFT] + (LANE_W+1)'(1);
  assign laneOut    = rounded[LANE_W:1];
  assign unusedBits = ^{prod, rounded[0]};

  // R2: the single overflowing product wraps to the most negative code
  always_comb begin
    if (opA == {1'b1, {(LANE_W-1){1'b0}}} && opB == {1'b1, {(LANE_W-1){1'b0}}})
      p_wrap_min_r2: assert (laneOut == {1'b1, {(LANE_W-1){1'b0}}} || $isunknown(opA));
  end
endmodule

// File: rtl/q15_rmul_ctrl.sv
`timescale 1ns/1ps
module q15_rmul_ctrl
  import q15_rmul_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [1:0] modeSel,
  input  logic       lenBit,
  output ctrl_t      ctrl,
  output logic       resValid,
  output logic       illegalOp
);
  mode_e modeDec;
  logic  badCombo;

  assign modeDec  = mode_e'(modeSel);
  assign badCombo = (modeDec == MODE_W128_ZERO) && lenBit;

  always_comb begin
    ctrl.flagIllegal = inValid && badCombo;
    ctrl.load        = inValid && !badCombo;
    ctrl.zeroRest    = (modeDec == MODE_W128_ZERO);
    case (modeDec)
      MODE_W64:  ctrl.span = SPAN_QUARTER;
      MODE_W256: ctrl.span = SPAN_FULL;
      default:   ctrl.span = SPAN_HALF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resValid  <= 1'b0;
      illegalOp <= 1'b0;
    end else begin
      resValid  <= ctrl.load;
      illegalOp <= ctrl.flagIllegal;
    end
  end

  p_valid_after_load_r8: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !(modeSel == 2'b10 && lenBit)) |=> (resValid && !illegalOp));
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> (!resValid && !illegalOp));
  p_illegal_flag_r9: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && modeSel == 2'b10 && lenBit) |=> (illegalOp && !resValid));
  p_len_ignored_r9: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && modeSel != 2'b10) |=> !illegalOp);
  p_flags_exclusive_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(resValid && illegalOp));
endmodule

// File: rtl/q15_rmul_dpath.sv
`timescale 1ns/1ps
module q15_rmul_dpath
  import q15_rmul_pkg::*;
#(
  parameter int LANE_W = 16,
  parameter int LANES  = 16,
  parameter int SHIFT  = 14
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctrl_t                    ctrl,
  input  logic [LANES*LANE_W-1:0]  srcA,
  input  logic [LANES*LANE_W-1:0]  srcB,
  input  logic [LANES*LANE_W-1:0]  oldDest,
  output logic [LANES*LANE_W-1:0]  resData
);
  localparam int DATA_W  = LANES * LANE_W;
  localparam int CNT_W   = $clog2(LANES + 1);
  localparam int QUARTER = LANES / 4;
  localparam int HALF    = LANES / 2;
  localparam int HALF_W  = HALF * LANE_W;
  localparam int QTR_W   = QUARTER * LANE_W;

  logic [DATA_W-1:0] laneRes;
  logic [DATA_W-1:0] merged;
  logic [CNT_W-1:0]  laneLimit;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    q15_rmul_lane #(.LANE_W(LANE_W), .SHIFT(SHIFT)) uLane (
      .opA    (srcA[g*LANE_W +: LANE_W]),
      .opB    (srcB[g*LANE_W +: LANE_W]),
      .laneOut(laneRes[g*LANE_W +: LANE_W])
    );
  end

  always_comb begin
    case (ctrl.span)
      SPAN_QUARTER: laneLimit = CNT_W'(QUARTER);
      SPAN_FULL:    laneLimit = CNT_W'(LANES);
      default:      laneLimit = CNT_W'(HALF);
    endcase
  end

  for (genvar g = 0; g < LANES; g++) begin : gMerge
    always_comb begin
      if (CNT_W'(g) < laneLimit)
        merged[g*LANE_W +: LANE_W] = laneRes[g*LANE_W +: LANE_W];
      else if (ctrl.zeroRest)
        merged[g*LANE_W +: LANE_W] = '0;
      else
        merged[g*LANE_W +: LANE_W] = oldDest[g*LANE_W +: LANE_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)          resData <= '0;
    else if (ctrl.load) resData <= merged;
  end

  p_hold_unless_load_r8: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.load |=> $stable(resData));
  p_narrow_keep_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.load && ctrl.span == SPAN_QUARTER) |=>
      resData[DATA_W-1:QTR_W] == $past(oldDest[DATA_W-1:QTR_W]));
  p_half_keep_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.load && ctrl.span == SPAN_HALF && !ctrl.zeroRest) |=>
      resData[DATA_W-1:HALF_W] == $past(oldDest[DATA_W-1:HALF_W]));
  p_half_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.load && ctrl.zeroRest) |=> resData[DATA_W-1:HALF_W] == '0);
endmodule

// File: rtl/q15_rmul_unit.sv
`timescale 1ns/1ps
module q15_rmul_unit
  import q15_rmul_pkg::*;
#(
  parameter int LANE_W = 16,
  parameter int LANES  = 16,
  parameter int SHIFT  = 14
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    inValid,
  input  logic [1:0]              modeSel,
  input  logic                    lenBit,
  input  logic [LANES*LANE_W-1:0] srcA,
  input  logic [LANES*LANE_W-1:0] srcB,
  input  logic [LANES*LANE_W-1:0] oldDest,
  output logic [LANES*LANE_W-1:0] resData,
  output logic                    resValid,
  output logic                    illegalOp
);
  ctrl_t ctrl;

  q15_rmul_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .modeSel  (modeSel),
    .lenBit   (lenBit),
    .ctrl     (ctrl),
    .resValid (resValid),
    .illegalOp(illegalOp)
  );

  q15_rmul_dpath #(.LANE_W(LANE_W), .LANES(LANES), .SHIFT(SHIFT)) uDpath (
    .clk    (clk),
    .rstN   (rstN),
    .ctrl   (ctrl),
    .srcA   (srcA),
    .srcB   (srcB),
    .oldDest(oldDest),
    .resData(resData)
  );
endmodule

// File: tb/q15_rmul_unit_test.sv
`timescale 1ns/1ps
module q15_rmul_unit_test;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic [1:0]   modeSel = 2'b00;
  logic         lenBit = 1'b0;
  logic [255:0] srcA = '0, srcB = '0, oldDest = '0;
  logic [255:0] resData;
  logic         resValid, illegalOp;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  logic [255:0] expData = '0;
  logic         expValid = 1'b0;
  logic         expIll = 1'b0;

  always #5 clk = ~clk;

  q15_rmul_unit uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .modeSel(modeSel), .lenBit(lenBit),
    .srcA(srcA), .srcB(srcB), .oldDest(oldDest),
    .resData(resData), .resValid(resValid), .illegalOp(illegalOp)
  );

  function automatic logic [15:0] refLane(logic [15:0] x, logic [15:0] y);
    int a = $signed(x);
    int b = $signed(y);
    int p = a * b;
    p = (p >>> 14) + 1;
    return p[16:1];
  endfunction

  function automatic logic [255:0] refModel(logic [1:0] m, logic [255:0] a,
                                            logic [255:0] b, logic [255:0] o);
    logic [255:0] r;
    int n = (m == 2'b00) ? 4 : (m == 2'b11) ? 16 : 8;
    for (int k = 0; k < 16; k++) begin
      if (k < n)            r[k*16 +: 16] = refLane(a[k*16 +: 16], b[k*16 +: 16]);
      else if (m == 2'b10)  r[k*16 +: 16] = 16'h0;
      else                  r[k*16 +: 16] = o[k*16 +: 16];
    end
    return r;
  endfunction

  function automatic logic [255:0] rand256();
    logic [255:0] v;
    for (int k = 0; k < 8; k++) v[k*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic check(input string tag, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive at a falling edge, verify at the next falling edge
  task automatic step(input logic v, input logic [1:0] m, input logic len,
                      input logic [255:0] a, input logic [255:0] b,
                      input logic [255:0] o, input string tag);
    inValid = v; modeSel = m; lenBit = len; srcA = a; srcB = b; oldDest = o;
    if (v && !(m == 2'b10 && len)) begin
      expData = refModel(m, a, b, o); expValid = 1'b1; expIll = 1'b0;
    end else if (v) begin
      expValid = 1'b0; expIll = 1'b1;
    end else begin
      expValid = 1'b0; expIll = 1'b0;
    end
    @(negedge clk);
    check(tag, resData, expData);
    check("R8 valid", {255'b0, resValid}, {255'b0, expValid});
    check("R9 illegal", {255'b0, illegalOp}, {255'b0, expIll});
  endtask

  function automatic string modeTag(logic [1:0] m);
    case (m)
      2'b00:   return "R1 R4";
      2'b01:   return "R1 R5";
      2'b10:   return "R1 R6";
      default: return "R1 R7";
    endcase
  endfunction

  task automatic finish();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      finish();
    end
  end

  initial begin
    logic [255:0] a, b, o;
    repeat (3) @(negedge clk);
    check("R10 data", resData, '0);
    check("R10 flags", {254'b0, resValid, illegalOp}, '0);
    rstN = 1'b1;

    // R2 corner lanes, 16-lane mode
    a = '0; b = '0;
    a[15:0]    = 16'h8000; b[15:0]    = 16'h8000;
    a[31:16]   = 16'h7FFF; b[31:16]   = 16'h7FFF;
    a[47:32]   = 16'h0001; b[47:32]   = 16'h0001;
    a[63:48]   = 16'hFFFF; b[63:48]   = 16'h0001;
    a[79:64]   = 16'h0000; b[79:64]   = 16'h7FFF;
    a[95:80]   = 16'h4000; b[95:80]   = 16'h4000;
    step(1'b1, 2'b11, 1'b0, a, b, '0, "R2 R7");
    check("R2 min*min", {240'b0, resData[15:0]}, {240'b0, 16'h8000});
    check("R2 max*max", {240'b0, resData[31:16]}, {240'b0, 16'h7FFE});
    check("R2 one/neg/zero", {208'b0, resData[79:32]}, '0);
    check("R1 half*half", {240'b0, resData[95:80]}, {240'b0, 16'h2000});

    // R3 single lane placement
    a = '0; b = '0;
    a[16*11 +: 16] = 16'h4000; b[16*11 +: 16] = 16'h4000;
    step(1'b1, 2'b11, 1'b0, a, b, '1, "R3 R7");
    check("R3 lane11", resData, 256'h2000 << (16*11));

    // R4..R6 merge with a visible old value
    o = rand256();
    step(1'b1, 2'b00, 1'b0, a, b, o, "R4");
    check("R4 upper", resData[255:64], o[255:64]);
    step(1'b1, 2'b01, 1'b1, rand256(), rand256(), o, "R5 R9");
    check("R5 upper", resData[255:128], o[255:128]);
    step(1'b1, 2'b10, 1'b0, rand256(), rand256(), o, "R6");
    check("R6 upper", resData[255:128], '0);

    // R9 illegal holds, R8 idle holds
    step(1'b1, 2'b10, 1'b1, rand256(), rand256(), rand256(), "R9 hold");
    step(1'b0, 2'b11, 1'b0, rand256(), rand256(), rand256(), "R8 hold");

    // random mix over all modes
    for (int t = 0; t < 400; t++) begin
      logic [1:0] m = 2'($urandom);
      logic v = ($urandom % 8) != 0;
      logic len = 1'($urandom);
      string tag = !v ? "R8 hold" : (m == 2'b10 && len) ? "R9 hold" : modeTag(m);
      step(v, m, len, rand256(), rand256(), rand256(), tag);
    end

    // reset mid-stream
    rstN = 1'b0; inValid = 1'b0;
    @(negedge clk);
    check("R10 data", resData, '0);
    check("R10 flags", {254'b0, resValid, illegalOp}, '0);
    finish();
  end
endmodule